// File: doc/BRIEF.md
# Acquisition Trigger and Gate Sequencer

This block runs one multi-channel sampling sequence. Configuration fields choose what starts the run (a software strobe, an external trigger pin or an analog-trigger hit), what ends the pre-trigger phase (a separate stop pin or the analog-trigger hit) and which signal gates conversions. Each trigger is edge-detected with its own polarity. A pacer tick, taken as is or divided by a fixed prescale, is turned into convert enables while the run is open and the gate allows it.

The run counts conversions in its post-trigger phase with a 24-bit down counter. The counter is loaded from a 16-bit low half and an 8-bit high half when the run arms. Once the counter is exhausted the run finishes, and it stays finished until the master enable is removed. In pre/post mode the run first converts without counting, and the stop event opens the counted phase. A scan-end input from the conversion datapath marks scan boundaries, so that in multi-channel runs an inactive gate can wait for the current scan to finish.

Top module: `acq_seq`

## Requirements
- R1: After reset, conv_en_o, active_o, done_o and stop_flag_o are 0.
- R2: start_src_i = 01 starts on an edge of ext_trig_i, and 10 starts on an edge of atrig_hit_i. start_pol_i = 0 selects the rising edge and 1 the falling edge. Code 11 never starts a run.
- R3: soft_start_i starts a run only when start_src_i = 00. Under any other code it leaves active_o at 0.
- R4: A run arms only while enable_i is 1 and the count {cnt_hi_i, cnt_lo_i} is non-zero. Dropping enable_i returns the block to idle, with active_o, done_o and stop_flag_o at 0.
- R5: With prepost_en_i = 1, start_src_i = 10 and stop_src_i = 1, cfg_err_o is 1 and no start event arms a run.
- R6: gate_src_i codes: 00 means the gate is always open, 01 takes soft_gate_i, 10 takes ext_gate_i and 11 takes atrig_hit_i. gate_pol_i = 0 means active high and 1 means active low.
- R7: With gate_lvl_i = 1 conversions follow the active gate level. With gate_lvl_i = 0 the first active gate edge of a run opens the gate for the rest of the run.
- R8: With seq_gate_i = 1 and chan_mode_i not 00 (00 one channel, 01 two, 10 four, 11 four transient), a level gate that goes inactive after a conversion keeps conversions enabled until scan_end_i. With seq_gate_i = 0 it closes at once.
- R9: conv_en_o is 0 while soft_gate_i is 0 or while no run is active.
- R10: In pre/post mode, conversions are not counted until a stop edge arrives. That edge comes from ext_stop_i when stop_src_i = 0 or from atrig_hit_i when it is 1, with polarity set by stop_pol_i (0 rising, 1 falling). The edge sets stop_flag_o.
- R11: Each counted conversion decrements the count. done_o rises one clock after the count reaches zero, and active_o falls in that same clock.
- R12: With psc_en_i = 1 only every 400th tick_i paces a conversion. With psc_en_i = 0 every tick does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Master run enable |
| start_src_i | input | 2 | Start source: 00 software, 01 pin, 10 analog, 11 none |
| start_pol_i | input | 1 | Start edge: 0 rising, 1 falling |
| prepost_en_i | input | 1 | Pre/post-trigger mode |
| stop_src_i | input | 1 | Stop source: 0 pin, 1 analog |
| stop_pol_i | input | 1 | Stop edge: 0 rising, 1 falling |
| gate_src_i | input | 2 | Gate source select |
| gate_pol_i | input | 1 | Gate polarity: 0 active high |
| gate_lvl_i | input | 1 | 1 level gate, 0 edge gate |
| seq_gate_i | input | 1 | Defer gate pause to scan end |
| soft_gate_i | input | 1 | Software gate, 0 inhibits all conversions |
| chan_mode_i | input | 2 | Channel mode |
| psc_en_i | input | 1 | Enable divide-by-400 pacer prescale |
| cnt_lo_i | input | 16 | Sample count low half |
| cnt_hi_i | input | 8 | Sample count high half |
| soft_start_i | input | 1 | Software start strobe |
| ext_trig_i | input | 1 | External start trigger pin |
| ext_stop_i | input | 1 | External stop trigger pin |
| ext_gate_i | input | 1 | External gate pin |
| atrig_hit_i | input | 1 | Analog trigger comparator hit |
| tick_i | input | 1 | Timebase tick |
| scan_end_i | input | 1 | Current scan finished |
| conv_en_o | output | 1 | Convert enable pulse |
| active_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete |
| stop_flag_o | output | 1 | Stop event seen |
| cfg_err_o | output | 1 | Invalid trigger configuration |

## Verification
A wrong sequencer state shows on active_o and done_o within one clock, because both are decoded from the state register. A corrupted count shows as done_o rising early or late against the number of convert enables issued. A stale gate latch or scan-hold flag shows as a convert enable in a cycle where the gate is inactive, visible in the same cycle. A prescaler out of step shifts the cycle of the next paced enable. A behavioural model compares every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST, ST_DONE} run_state_e;

  localparam logic [1:0] START_SW    = 2'b00;
  localparam logic [1:0] START_PIN   = 2'b01;
  localparam logic [1:0] START_ATRIG = 2'b10;

  localparam logic [1:0] GATE_OFF  = 2'b00;
  localparam logic [1:0] GATE_SOFT = 2'b01;
  localparam logic [1:0] GATE_PIN  = 2'b10;
  localparam logic [1:0] GATE_ATRIG = 2'b11;

  localparam logic [1:0] CHAN_ONE = 2'b00;
endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic pulse_o
);
  logic prev_q;

  // prev resets high so no edge is seen right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= act_i;
  end

  assign pulse_o = act_i & ~prev_q;
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int unsigned PSC_DIV = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic psc_en_i,
  output logic pace_o
);
  localparam int unsigned DIV_W = $clog2(PSC_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PSC_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!psc_en_i) div_q <= '0;
    else if (tick_i)   div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
  end

  assign pace_o = tick_i & (~psc_en_i | (div_q == DIV_LAST));

  p_div_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_LAST);
  p_psc_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_en_i && pace_o) |=> !pace_o);
endmodule

// File: rtl/acq_gate.sv
module acq_gate
  import acq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] gate_src_i,
  input  logic       gate_pol_i,
  input  logic       gate_lvl_i,
  input  logic       seq_gate_i,
  input  logic [1:0] chan_mode_i,
  input  logic       soft_gate_i,
  input  logic       ext_gate_i,
  input  logic       atrig_hit_i,
  input  logic       running_i,
  input  logic       conv_i,
  input  logic       scan_end_i,
  output logic       open_o
);
  logic g_sel, g_act, g_edge, latch_q, in_scan_q, hold;

  always_comb begin
    unique case (gate_src_i)
      GATE_SOFT: g_sel = soft_gate_i;
      GATE_PIN:  g_sel = ext_gate_i;
      default:   g_sel = atrig_hit_i;
    endcase
  end

  assign g_act = (gate_src_i == GATE_OFF) ? 1'b1 : (g_sel ^ gate_pol_i);

  acq_edge_det u_gate_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (g_act),
    .pulse_o(g_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q   <= 1'b0;
      in_scan_q <= 1'b0;
    end else if (!running_i) begin
      latch_q   <= 1'b0;
      in_scan_q <= 1'b0;
    end else begin
      if (g_edge) latch_q <= 1'b1;
      if (scan_end_i)  in_scan_q <= 1'b0;
      else if (conv_i) in_scan_q <= 1'b1;
    end
  end

  assign hold = seq_gate_i & (chan_mode_i != CHAN_ONE) & gate_lvl_i & in_scan_q;

  always_comb begin
    if (gate_src_i == GATE_OFF) open_o = 1'b1;
    else if (gate_lvl_i)        open_o = g_act | hold;
    else                        open_o = latch_q | g_edge;
  end

  p_latch_in_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q |-> $past(running_i));
  p_scan_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && scan_end_i) |=> !in_scan_q);
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int unsigned LO_W    = 16,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned PSC_DIV = 400
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic [1:0]      start_src_i,
  input  logic            start_pol_i,
  input  logic            prepost_en_i,
  input  logic            stop_src_i,
  input  logic            stop_pol_i,
  input  logic [1:0]      gate_src_i,
  input  logic            gate_pol_i,
  input  logic            gate_lvl_i,
  input  logic            seq_gate_i,
  input  logic            soft_gate_i,
  input  logic [1:0]      chan_mode_i,
  input  logic            psc_en_i,
  input  logic [LO_W-1:0] cnt_lo_i,
  input  logic [HI_W-1:0] cnt_hi_i,
  input  logic            soft_start_i,
  input  logic            ext_trig_i,
  input  logic            ext_stop_i,
  input  logic            ext_gate_i,
  input  logic            atrig_hit_i,
  input  logic            tick_i,
  input  logic            scan_end_i,
  output logic            conv_en_o,
  output logic            active_o,
  output logic            done_o,
  output logic            stop_flag_o,
  output logic            cfg_err_o
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             stop_q, stop_d;
  logic             start_sel, start_edge, start_evt;
  logic             stop_sel, stop_edge;
  logic             pace, gate_open, running, cnt_zero;

  always_comb begin
    unique case (start_src_i)
      START_PIN:   start_sel = ext_trig_i;
      START_ATRIG: start_sel = atrig_hit_i;
      default:     start_sel = 1'b0;
    endcase
  end
  assign stop_sel = stop_src_i ? atrig_hit_i : ext_stop_i;

  acq_edge_det u_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (start_sel ^ start_pol_i),
    .pulse_o(start_edge)
  );

  acq_edge_det u_stop_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (stop_sel ^ stop_pol_i),
    .pulse_o(stop_edge)
  );

  acq_pacer #(.PSC_DIV(PSC_DIV)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .psc_en_i(psc_en_i),
    .pace_o  (pace)
  );

  acq_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_src_i (gate_src_i),
    .gate_pol_i (gate_pol_i),
    .gate_lvl_i (gate_lvl_i),
    .seq_gate_i (seq_gate_i),
    .chan_mode_i(chan_mode_i),
    .soft_gate_i(soft_gate_i),
    .ext_gate_i (ext_gate_i),
    .atrig_hit_i(atrig_hit_i),
    .running_i  (running),
    .conv_i     (conv_en_o),
    .scan_end_i (scan_end_i),
    .open_o     (gate_open)
  );

  assign start_evt = (start_src_i == START_SW) ? soft_start_i : start_edge;
  assign cfg_err_o = prepost_en_i & (start_src_i == START_ATRIG) & stop_src_i;
  assign load_val  = {cnt_hi_i, cnt_lo_i};
  assign running   = (state_q == ST_PRE) | (state_q == ST_POST);
  assign cnt_zero  = (cnt_q == '0);
  assign conv_en_o = running & pace & soft_gate_i & gate_open
                   & ~((state_q == ST_POST) & cnt_zero);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      stop_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_evt && !cfg_err_o && load_val != '0) begin
          state_d = prepost_en_i ? ST_PRE : ST_POST;
          cnt_d   = load_val;
        end
        ST_PRE: if (stop_edge) begin
          state_d = ST_POST;
          stop_d  = 1'b1;
        end
        ST_POST: begin
          if (cnt_zero)       state_d = ST_DONE;
          else if (conv_en_o) cnt_d   = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
    end
  end

  assign active_o    = running;
  assign done_o      = (state_q == ST_DONE);
  assign stop_flag_o = stop_q;

  p_zero_to_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && cnt_zero && enable_i) |=> (done_o && !active_o));
  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && cnt_zero) |=> cnt_zero);
  p_conv_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |-> (soft_gate_i && active_o));
  p_cfg_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && cfg_err_o) |=> !active_o);
  p_arm_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && (load_val == '0 || !enable_i)) |=> !active_o);
  p_stop_from_pre_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_flag_o) |-> $past(state_q == ST_PRE));
endmodule

// File: tb/acq_seq_tb.sv
module acq_seq_tb;
  localparam int PSC = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic enable = 0, start_pol = 0, prepost = 0, stop_src = 0, stop_pol = 0;
  logic gate_pol = 0, gate_lvl = 0, seq_gate = 0, soft_gate = 1, psc_en = 0;
  logic [1:0] start_src = 0, gate_src = 0, chan_mode = 0;
  logic [15:0] cnt_lo = 16'd3;
  logic [7:0]  cnt_hi = 8'd0;
  logic soft_start = 0, ext_trig = 0, ext_stop = 0, ext_gate = 0, atrig = 0;
  logic tick = 1, scan_end = 0;
  logic conv_en, active, done, stop_flag, cfg_err;

  acq_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable), .start_src_i(start_src),
    .start_pol_i(start_pol), .prepost_en_i(prepost), .stop_src_i(stop_src),
    .stop_pol_i(stop_pol), .gate_src_i(gate_src), .gate_pol_i(gate_pol),
    .gate_lvl_i(gate_lvl), .seq_gate_i(seq_gate), .soft_gate_i(soft_gate),
    .chan_mode_i(chan_mode), .psc_en_i(psc_en), .cnt_lo_i(cnt_lo),
    .cnt_hi_i(cnt_hi), .soft_start_i(soft_start), .ext_trig_i(ext_trig),
    .ext_stop_i(ext_stop), .ext_gate_i(ext_gate), .atrig_hit_i(atrig),
    .tick_i(tick), .scan_end_i(scan_end), .conv_en_o(conv_en),
    .active_o(active), .done_o(done), .stop_flag_o(stop_flag), .cfg_err_o(cfg_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // behavioural reference: 0 idle, 1 pre, 2 post, 3 done
  int m_state = 0, m_div = 0;
  longint m_cnt = 0;
  bit m_stop = 0, m_sp = 1, m_tp = 1, m_gp = 1, m_latch = 0, m_scan = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      m_state = 0; m_div = 0; m_cnt = 0; m_stop = 0;
      m_sp = 1; m_tp = 1; m_gp = 1; m_latch = 0; m_scan = 0;
    end else begin
      bit s_act, t_act, g_act, g_sel, s_evt, t_evt, g_edge, pace, open, run, conv, err;
      s_act = ((start_src == 1) ? ext_trig : (start_src == 2) ? atrig : 1'b0) ^ start_pol;
      t_act = (stop_src ? atrig : ext_stop) ^ stop_pol;
      g_sel = (gate_src == 1) ? soft_gate : (gate_src == 2) ? ext_gate : atrig;
      g_act = (gate_src == 0) ? 1'b1 : (g_sel ^ gate_pol);
      s_evt = (start_src == 0) ? soft_start : (s_act && !m_sp);
      t_evt = t_act && !m_tp;
      g_edge = g_act && !m_gp;
      pace = tick && (!psc_en || m_div == PSC - 1);
      if (gate_src == 0) open = 1;
      else if (gate_lvl) open = g_act || (seq_gate && chan_mode != 0 && m_scan);
      else open = m_latch || g_edge;
      run = (m_state == 1 || m_state == 2);
      conv = run && pace && soft_gate && open && !(m_state == 2 && m_cnt == 0);
      err = prepost && start_src == 2 && stop_src;
      chk("R9/R11 conv_en", conv_en, conv);
      chk("R4/R11 active", active, run);
      chk("R11 done", done, m_state == 3);
      chk("R10 stop_flag", stop_flag, m_stop);
      chk("R5 cfg_err", cfg_err, err);
      // advance to post-edge state
      m_sp = s_act; m_tp = t_act; m_gp = g_act;
      if (!psc_en) m_div = 0; else if (tick) m_div = (m_div == PSC - 1) ? 0 : m_div + 1;
      if (!run) begin m_latch = 0; m_scan = 0; end
      else begin
        if (g_edge) m_latch = 1;
        if (scan_end) m_scan = 0; else if (conv) m_scan = 1;
      end
      if (!enable) begin m_state = 0; m_stop = 0; end
      else case (m_state)
        0: if (s_evt && !err && {cnt_hi, cnt_lo} != 0) begin
             m_state = prepost ? 1 : 2; m_cnt = {cnt_hi, cnt_lo};
           end
        1: if (t_evt) begin m_state = 2; m_stop = 1; end
        2: if (m_cnt == 0) m_state = 3; else if (conv) m_cnt--;
        default: ;
      endcase
    end
  end

  task automatic finish_run();
    enable = 0;
    step(2);
  endtask

  task automatic sw_start();
    enable = 1; soft_start = 1; step(1); soft_start = 0;
  endtask

  initial begin
    step(2);
    chk("R1 conv_en reset", conv_en, 0);
    chk("R1 active reset", active, 0);
    chk("R1 done reset", done, 0);
    chk("R1 stop_flag reset", stop_flag, 0);
    rst_ni = 1; step(2);

    // R3 / R11: software start, count 3
    sw_start(); step(10);
    chk("R11 done after count", done, 1);
    chk("R11 active low at done", active, 0);
    finish_run();

    // R3: soft start ignored with pin source; R2 rising pin start
    start_src = 2'b01; sw_start(); step(3);
    chk("R3 soft start ignored", active, 0);
    ext_trig = 1; step(2);
    chk("R2 rising pin start", active, 1);
    step(10); chk("R2 pin run completes", done, 1);
    finish_run(); ext_trig = 0; step(1);

    // R2 falling edge
    start_pol = 1; ext_trig = 1; step(2); enable = 1; step(2);
    chk("R2 no start while high", active, 0);
    ext_trig = 0; step(2);
    chk("R2 falling pin start", active, 1);
    finish_run(); start_pol = 0;

    // R10 pre/post with falling stop on pin
    start_src = 2'b00; prepost = 1; stop_pol = 1; cnt_lo = 2;
    sw_start(); step(5);
    chk("R10 pre phase holds", active, 1);
    chk("R10 no stop yet", stop_flag, 0);
    ext_stop = 1; step(2);
    chk("R10 rising ignored", stop_flag, 0);
    ext_stop = 0; step(2);
    chk("R10 stop flag set", stop_flag, 1);
    step(6); chk("R10 post phase done", done, 1);
    finish_run(); ext_stop = 0; stop_pol = 0;

    // R5 analog start with analog stop is invalid
    start_src = 2'b10; stop_src = 1; enable = 1; step(1);
    chk("R5 cfg_err", cfg_err, 1);
    atrig = 1; step(3);
    chk("R5 no arm", active, 0);
    atrig = 0; stop_src = 0; step(2);
    atrig = 1; step(2);
    chk("R2 analog start", active, 1);
    finish_run(); atrig = 0; prepost = 0; start_src = 2'b00;

    // R4 zero count and enable drop
    cnt_lo = 0; sw_start(); step(2);
    chk("R4 zero count no arm", active, 0);
    finish_run();
    cnt_hi = 1; sw_start(); step(3);
    chk("R4 high half arms", active, 1);
    enable = 0; step(1);
    chk("R4 enable drop idles", active, 0);
    chk("R4 enable drop no done", done, 0);
    cnt_hi = 0; cnt_lo = 3; step(1);

    // R6/R7 level gate on pin, active low
    gate_src = 2'b10; gate_pol = 1; gate_lvl = 1; ext_gate = 1;
    sw_start(); step(4);
    chk("R6 gate closed", conv_en, 0);
    ext_gate = 0; #1;
    chk("R6 active low gate opens", conv_en, 1);
    step(8); chk("R7 level run done", done, 1);
    finish_run();

    // R7 edge gate latches
    gate_pol = 0; gate_lvl = 0; ext_gate = 0; cnt_lo = 20;
    sw_start(); step(3);
    chk("R7 edge gate closed", conv_en, 0);
    ext_gate = 1; step(1); ext_gate = 0; step(1);
    chk("R7 edge gate stays open", conv_en, 1);
    finish_run();

    // R6 software gate source
    gate_src = 2'b01; gate_lvl = 1; sw_start(); step(3);
    chk("R6 soft gate source", conv_en, 1);
    finish_run();

    // R9 soft gate low inhibits
    gate_src = 2'b00; soft_gate = 0; sw_start(); step(3);
    chk("R9 soft gate inhibits", conv_en, 0);
    chk("R9 run still active", active, 1);
    soft_gate = 1; finish_run();

    // R8 deferred pause in multi-channel mode
    gate_src = 2'b10; gate_lvl = 1; ext_gate = 1; seq_gate = 1; chan_mode = 2'b10;
    cnt_lo = 100; sw_start(); step(2);
    ext_gate = 0; #1;
    chk("R8 held until scan end", conv_en, 1);
    scan_end = 1; step(1); scan_end = 0; #1;
    chk("R8 paused after scan end", conv_en, 0);
    seq_gate = 0; ext_gate = 1; step(2); ext_gate = 0; #1;
    chk("R8 immediate pause", conv_en, 0);
    finish_run(); gate_src = 2'b00; chan_mode = 2'b00;

    // R12 prescaled pacer
    cnt_lo = 2; psc_en = 1; sw_start(); step(300);
    chk("R12 prescaled still running", active, 1);
    step(600);
    chk("R12 prescaled done", done, 1);
    finish_run(); psc_en = 0;

    step(4);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule